// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recently used page translations and turns a 32-bit virtual address into a 24-bit physical address in the same cycle. Pages are 1024 bytes: the upper 22 bits of the virtual address name the virtual page, and the lower 10 bits pass through untranslated beneath a 14-bit physical page number. Every entry is compared against the incoming page number in parallel, so any translation may sit in any slot.

A second port belongs to the kernel agent that manages the page table. It loads translations after a miss and drops the translation for a page that is being swapped out. When a load has to reuse an occupied slot and that slot's page has been written through the buffer, the block reports the departing page number during the same cycle. The agent can then mark that page modified in the page table before the slot is overwritten. Clean departing pages are dropped without any report.

Top module: `tlb_xlate`

## Requirements
- R1: A synchronous active-high reset clears every valid and dirty bit and returns the replacement pointer to slot 0. After reset every lookup misses.
- R2: A lookup hits when a valid entry's page tag equals vaddr[31:10]. The physical address is then {entry physical page, vaddr[9:0]} in the same cycle. It reads as zero whenever the lookup does not hit.
- R3: A lookup with the write flag set that hits marks that entry dirty. A read hit leaves the dirty bit as it was.
- R4: With the lookup request high and no valid matching entry, the miss output is 1 and the hit output is 0. With the request low, both outputs are 0.
- R5: A load of a page that is not present goes to the lowest-indexed slot whose valid bit is clear. It sets valid, clears dirty, reports no eviction and leaves the pointer unchanged.
- R6: When every slot is valid, a load of a new page replaces the slot named by the round-robin pointer. The pointer then advances by one, wrapping from N-1 to 0. It moves on no other event.
- R7: During a replacing load whose victim is dirty, the eviction strobe is 1 and carries the victim's page number in the same cycle. A clean victim leaves the strobe at 0.
- R8: An invalidate command clears the valid and dirty bits of the entry matching its page. It has no effect when no entry matches, and it is ignored in a cycle that also loads.
- R9: A load of a page already held in a valid entry rewrites that entry's physical page in place and keeps its dirty bit. It creates no second entry, reports no eviction and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent (exception request) |
| lk_paddr | output | 24 | Physical address, zero unless hit |
| mt_fill | input | 1 | Load a translation |
| mt_inval | input | 1 | Drop the translation of mt_vpn |
| mt_vpn | input | 22 | Virtual page for load or invalidate |
| mt_ppn | input | 14 | Physical page for load |
| ev_valid | output | 1 | Dirty victim being evicted this cycle |
| ev_vpn | output | 22 | Page number of the dirty victim |

## Verification
The assertions check several properties on every cycle: hit and miss are exclusive and only appear with a request, and at most one entry ever matches a lookup. An eviction report only appears during a load, and a dirty bit never outlives its valid bit. The pointer moves exactly on replacements, and a write hit leaves its entry dirty. Which slot a load chooses, and whether a victim carries its dirty history, can only be shown by the bench's scenarios. These cover filling every slot, write hits before wraparound, invalidating a middle slot so it is refilled before the pointer's slot, and in-place reloads. Reset in the middle of a run is covered the same way.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 24;
  localparam int OFF_W = 10;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] va_off(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  function automatic int unsigned rr_step(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            oh,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign oh[i] = vld[i] && (tags[i] == key);
  end

  assign hit = |oh;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (oh[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     vld,
  input  logic             advance,
  output logic             has_free,
  output logic [IDX_W-1:0] free_idx,
  output logic [IDX_W-1:0] ptr
);
  assign has_free = ~&vld;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (advance) ptr <= IDX_W'(rr_step(int'(ptr), N));
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic              lk_wr,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              mt_fill,
  input  logic              mt_inval,
  input  logic [VPN_W-1:0]  mt_vpn,
  input  logic [PPN_W-1:0]  mt_ppn,
  output logic              ev_valid,
  output logic [VPN_W-1:0]  ev_vpn
);
  logic [N-1:0]            ent_v, ent_d;
  logic [N-1:0][VPN_W-1:0] ent_tag;
  logic [N-1:0][PPN_W-1:0] ent_ppn;

  // lookup side
  logic [N-1:0]     lk_oh;
  logic             lk_match;
  logic [IDX_W-1:0] lk_idx;
  logic [PPN_W-1:0] lk_ppn;
  logic             wr_hit;

  tlb_cam #(.N(N), .IDX_W(IDX_W)) u_lk_cam (
    .vld(ent_v), .tags(ent_tag), .key(va_vpn(lk_vaddr)),
    .oh(lk_oh), .hit(lk_match), .idx(lk_idx)
  );

  assign lk_ppn   = ent_ppn[lk_idx];
  assign lk_hit   = lk_req && lk_match;
  assign lk_miss  = lk_req && !lk_match;
  assign lk_paddr = lk_hit ? join_pa(lk_ppn, va_off(lk_vaddr)) : '0;
  assign wr_hit   = lk_hit && lk_wr;

  // maintenance side
  logic [N-1:0]     mt_oh;
  logic             mt_match;
  logic [IDX_W-1:0] mt_idx;
  logic             has_free;
  logic [IDX_W-1:0] free_idx, rr_ptr, fill_idx;
  logic             replace, inval_do;

  tlb_cam #(.N(N), .IDX_W(IDX_W)) u_mt_cam (
    .vld(ent_v), .tags(ent_tag), .key(mt_vpn),
    .oh(mt_oh), .hit(mt_match), .idx(mt_idx)
  );

  assign replace  = mt_fill && !mt_match && !has_free;
  assign inval_do = mt_inval && !mt_fill && mt_match;

  tlb_alloc #(.N(N), .IDX_W(IDX_W)) u_alloc (
    .clk(clk), .rst(rst), .vld(ent_v), .advance(replace),
    .has_free(has_free), .free_idx(free_idx), .ptr(rr_ptr)
  );

  always_comb begin
    if (mt_match)      fill_idx = mt_idx;
    else if (has_free) fill_idx = free_idx;
    else               fill_idx = rr_ptr;
  end

  assign ev_valid = replace && ent_d[rr_ptr];
  assign ev_vpn   = ev_valid ? ent_tag[rr_ptr] : '0;

  // entry storage: load beats invalidate beats write-hit marking
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic load_me, drop_me, mark_me;
    assign load_me = mt_fill && (fill_idx == IDX_W'(i));
    assign drop_me = inval_do && mt_oh[i];
    assign mark_me = wr_hit && lk_oh[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_v[i]   <= 1'b0;
        ent_d[i]   <= 1'b0;
        ent_tag[i] <= '0;
        ent_ppn[i] <= '0;
      end else if (load_me) begin
        ent_v[i]   <= 1'b1;
        ent_d[i]   <= mt_match ? (ent_d[i] | mark_me) : 1'b0;
        ent_tag[i] <= mt_vpn;
        ent_ppn[i] <= mt_ppn;
      end else if (drop_me) begin
        ent_v[i]   <= 1'b0;
        ent_d[i]   <= 1'b0;
      end else if (mark_me) begin
        ent_d[i]   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_req,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             mt_fill,
  input logic             mt_inval,
  input logic             ev_valid,
  input logic             wr_hit,
  input logic             replace,
  input logic [N-1:0]     lk_oh,
  input logic [N-1:0]     ent_v,
  input logic [N-1:0]     ent_d,
  input logic [IDX_W-1:0] rr_ptr
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ent_v == '0 && ent_d == '0 && rr_ptr == '0));

  a_r4_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
    lk_req |-> (lk_hit != lk_miss));

  a_r4_quiet_no_req: assert property (@(posedge clk) disable iff (rst)
    !lk_req |-> (!lk_hit && !lk_miss));

  a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_oh));

  a_r7_evict_in_fill: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (mt_fill && replace));

  a_r8_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (ent_d & ~ent_v) == '0);

  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    replace |=> (rr_ptr == IDX_W'(rr_step(int'($past(rr_ptr)), N))));

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !replace |=> $stable(rr_ptr));

  a_r3_write_marks: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !mt_fill && !mt_inval) |=> ((ent_d & $past(lk_oh)) != '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .mt_fill(mt_fill), .mt_inval(mt_inval), .ev_valid(ev_valid),
  .wr_hit(wr_hit), .replace(replace), .lk_oh(lk_oh),
  .ent_v(ent_v), .ent_d(ent_d), .rr_ptr(rr_ptr)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int PER = 10;
  localparam int N   = 8;

  logic        clk = 0, rst = 1;
  logic        lk_req = 0, lk_wr = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss;
  logic [23:0] lk_paddr;
  logic        mt_fill = 0, mt_inval = 0;
  logic [21:0] mt_vpn = '0;
  logic [13:0] mt_ppn = '0;
  logic        ev_valid;
  logic [21:0] ev_vpn;

  tlb_xlate #(.N(N)) dut (.*);

  always #(PER/2) clk = ~clk;

  typedef struct {
    bit          lk;
    bit          hit;
    logic [23:0] pa;
    bit          ev;
    logic [21:0] evpn;
    string       rq;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;

  // reference state restated from the requirements
  bit          mv[N], md[N];
  logic [21:0] mtag[N];
  logic [13:0] mppn[N];
  int          mptr;

  function automatic int find(input logic [21:0] vpn);
    for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == vpn) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mv[i] = 0; md[i] = 0; end
    mptr = 0;
  endtask

  task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // driver: one operation per cycle, expectation pushed to the scoreboard
  task automatic op(input bit do_lk, input bit wr, input logic [31:0] va,
                    input bit do_fill, input logic [21:0] fv, input logic [13:0] fp,
                    input bit do_inv, input logic [21:0] iv, input string rq);
    exp_t e;
    int li, fi, tgt;
    @(posedge clk); #1;
    lk_req = do_lk; lk_wr = wr; lk_vaddr = va;
    mt_fill = do_fill; mt_inval = do_inv; mt_vpn = do_fill ? fv : iv; mt_ppn = fp;
    e.rq = rq; e.lk = do_lk; e.ev = 0; e.evpn = '0;
    li = find(va[31:10]);
    e.hit = do_lk && li >= 0;
    e.pa  = e.hit ? {mppn[li], va[9:0]} : 24'h0;
    tgt = -1;
    if (do_fill) begin
      fi = find(fv);
      if (fi >= 0) tgt = fi;
      else begin
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) tgt = i;
        if (tgt < 0) begin
          tgt = mptr;
          e.ev = md[mptr];
          e.evpn = md[mptr] ? mtag[mptr] : '0;
          mptr = (mptr + 1) % N;
        end
      end
    end
    q.push_back(e);
    if (e.hit && wr) md[li] = 1;
    if (do_inv && !do_fill) begin
      fi = find(iv);
      if (fi >= 0) begin mv[fi] = 0; md[fi] = 0; end
    end
    if (do_fill) begin
      if (find(fv) != tgt) md[tgt] = 0;
      mv[tgt] = 1; mtag[tgt] = fv; mppn[tgt] = fp;
    end
  endtask

  task automatic look(input logic [21:0] vpn, input logic [9:0] off, input bit wr, input string rq);
    op(1, wr, {vpn, off}, 0, '0, '0, 0, '0, rq);
  endtask

  task automatic fill(input logic [21:0] vpn, input logic [13:0] ppn, input string rq);
    op(0, 0, '0, 1, vpn, ppn, 0, '0, rq);
  endtask

  task automatic inval(input logic [21:0] vpn, input string rq);
    op(0, 0, '0, 0, '0, '0, 1, vpn, rq);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    lk_req = 0; lk_wr = 0; mt_fill = 0; mt_inval = 0;
  endtask

  // monitor: compares mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.lk) begin
        cmp(e.rq, "hit", 32'(lk_hit), 32'(e.hit));
        cmp(e.hit ? e.rq : "R4", "miss", 32'(lk_miss), 32'(!e.hit));
        cmp(e.rq, "paddr", 32'(lk_paddr), 32'(e.pa));
      end else begin
        cmp("R4", "idle hit|miss", 32'({lk_hit, lk_miss}), 32'h0);
      end
      cmp(e.ev ? "R7" : e.rq, "ev_valid", 32'(ev_valid), 32'(e.ev));
      cmp("R7", "ev_vpn", 32'(ev_vpn), 32'(e.evpn));
    end
  end

  initial begin
    #(PER * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: nothing resident after reset
    look(22'h000000, 10'h000, 0, "R1");
    look(22'h3FFFFF, 10'h3FF, 0, "R1");
    look(22'h000123, 10'h010, 1, "R4");
    // R5: fill every slot in ascending order
    for (int i = 0; i < N; i++) fill(22'h100 + 22'(i), 14'h200 + 14'(i * 3), "R5");
    // R2: translations and offset passthrough
    for (int i = 0; i < N; i++) look(22'h100 + 22'(i), 10'(i * 37 + 5), 0, "R2");
    look(22'h1FF, 10'h3FF, 0, "R4");
    // R3: write hits mark slots 0 and 2, read hit on slot 1
    look(22'h100, 10'h001, 1, "R3");
    look(22'h102, 10'h002, 1, "R3");
    look(22'h101, 10'h003, 0, "R3");
    // R6/R7: replacements at pointer 0,1,2
    fill(22'h200, 14'h0AA, "R7");   // victim 0x100 dirty
    look(22'h100, 10'h000, 0, "R4");
    fill(22'h201, 14'h0AB, "R7");   // victim 0x101 clean
    fill(22'h202, 14'h0AC, "R7");   // victim 0x102 dirty
    look(22'h200, 10'h155, 0, "R2");
    // R8: unmatched invalidate has no effect
    inval(22'h3AB, "R8");
    for (int i = 3; i < N; i++) look(22'h100 + 22'(i), 10'h0, 0, "R8");
    // R8: invalidate slot 4, R5 refills it before the pointer's slot
    look(22'h104, 10'h0, 1, "R3");
    inval(22'h104, "R8");
    look(22'h104, 10'h0, 0, "R8");
    fill(22'h300, 14'h111, "R5");
    look(22'h300, 10'h0, 1, "R3");
    fill(22'h301, 14'h112, "R6");   // pointer 3, clean
    fill(22'h302, 14'h113, "R6");   // pointer 4: slot holding dirty 0x300
    // R9: in-place reload keeps dirty, no pointer movement
    look(22'h201, 10'h0, 1, "R3");
    fill(22'h201, 14'h3FF, "R9");
    look(22'h201, 10'h2A5, 0, "R9");
    // R8: invalidate ignored while a load happens
    op(0, 0, '0, 1, 22'h303, 14'h114, 1, '0, "R8");
    mt_vpn = 22'h303;
    look(22'h303, 10'h0, 0, "R8");
    // wrap pointer all the way round so slot 1 (dirty 0x201) departs
    for (int i = 0; i < N; i++) fill(22'h400 + 22'(i), 14'h020 + 14'(i), "R6");
    for (int i = 0; i < N; i++) look(22'h400 + 22'(i), 10'h07F, 0, "R2");
    // R1: reset mid-run
    idle();
    rst = 1;
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst = 0;
    look(22'h400, 10'h0, 0, "R1");
    look(22'h407, 10'h0, 1, "R1");
    fill(22'h500, 14'h001, "R1");   // pointer back at 0, free slot 0
    look(22'h500, 10'h3C3, 0, "R5");
    idle();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule